// File: doc/BRIEF.md
# Dynamic Voltage Scaling VID Sequencer

This block is the digital sequencer for one buck converter's output voltage code. The host writes a 7-bit target code. The sequencer moves the live code (`vid`) toward that target one code at a time, at a fixed pace, so that the output slews at a bounded rate. The pace depends on the step-size select: one code every 3 µs when codes are 10 mV apart, and one code every 6 µs when they are 25 mV apart. Both paces give at least 2.5 mV/µs. While the code is moving, the block masks power-good. It also asks the converter for forced PWM operation, unless decay mode is selected.

Target code 0 shuts the converter down. The code first walks down to the floor code 1, which stands for 0.5 V. One interval later, switching stops and the output drifts toward 0 V. Waking the converter with a target of 2 or more depends on the floor comparator. If the output is below the floor, the converter restarts at code 1 through a fixed 200 µs soft-start phase that does not force PWM. Otherwise it starts stepping directly from code 1. All intervals are parameters in clock cycles, derived from a clock-frequency parameter `CLK_KHZ`.

Top module: `dvs_vid_seq`

## Requirements
- R1: During and directly after reset: `vid`=0, `sw_en`=0, `force_pwm`=0, `ss_active`=0, `pg_mask`=1.
- R2: While regulating, the sequencer changes `vid` by exactly one code per step toward the effective target and stops on it. The effective target is `tgt_vid`, or code 1 when `tgt_vid`=0.
- R3: Steps are spaced STEP_SMALL = CLK_KHZ*3/1000 cycles when `step_large`=0 and STEP_LARGE = CLK_KHZ*6/1000 cycles when `step_large`=1. When the target changes from a steady state, the first new code appears one interval plus one cycle after the change.
- R4: `force_pwm` equals NOT `decay_en` from the start of stepping until power-good is unmasked. It is 0 when steady, when off, and during soft-start.
- R5: `pg_mask` stays 1 from the start of stepping until one step interval after `vid` reaches the target. It then drops to 0 and stays 0 while the code is held at the target.
- R6: With `tgt_vid`=0, the code steps down to 1. One step interval after reaching 1, `sw_en` falls to 0 and `vid` becomes 0. `pg_mask` stays 1 while off.
- R7: When off, a target of 2 or more with `below_floor`=1 sets `vid`=1 and `sw_en`=1 on the next edge. `ss_active` then stays 1 for SOFT = CLK_KHZ*200/1000 cycles with `force_pwm`=0. Stepping toward the target follows, with the first step one interval after `ss_active` falls.
- R8: When off, a target of 2 or more with `below_floor`=0 sets `vid`=1 and `sw_en`=1 on the next edge with no soft-start (`ss_active`=0). The first step comes one interval later.
- R9: When off, a target of 0 or 1 has no effect: `sw_en` stays 0 and `vid` stays 0.
- R10: A target change during a ramp takes effect at the next step boundary. That step moves one code toward the new target, one full interval after the previous step.
- R11: While switching stays enabled, `vid` never changes by more than one code between clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_vid | input | 7 | Host target code |
| step_large | input | 1 | 1: 25 mV codes (slow pace), 0: 10 mV codes |
| decay_en | input | 1 | 1: do not force PWM while stepping |
| below_floor | input | 1 | Output is below the 0.5 V floor |
| vid | output | 7 | Live voltage code to the DAC |
| sw_en | output | 1 | Converter switching enable |
| force_pwm | output | 1 | Request forced PWM operation |
| ss_active | output | 1 | Fixed soft-start phase in progress |
| pg_mask | output | 1 | Mask power-good reporting |

## Verification
On every cycle, the assertions check these properties:
- the live code moves by at most one code while switching;
- switching is off only at code 0 and stops only from the floor code;
- soft-start never coincides with forced PWM and always sits at the floor code with switching on;
- a steady, unmasked state holds the code on the previous target;
- forced PWM never appears while power-good is unmasked.

Only the bench scenarios can show the exact step spacing for both step sizes and the one-interval delay before power-good is released. The same applies to the length of the soft-start phase, the shutdown and the two wake-up paths, and the reversal of a ramp at the next step boundary.

// File: rtl/dvs_vid_pkg.sv
package dvs_vid_pkg;

  // Sequencer phases; the output decode depends only on these.
  typedef enum logic [2:0] {
    SEQ_OFF    = 3'd0,  // switching stopped, code parked at zero
    SEQ_SOFT   = 3'd1,  // fixed soft-start toward the floor code
    SEQ_RAMP   = 3'd2,  // paced stepping toward the target
    SEQ_SETTLE = 3'd3,  // one interval on target before unmasking
    SEQ_HOLD   = 3'd4   // regulating on target, power-good visible
  } seq_state_t;

  // Code that stands for the 0.5 V floor.
  localparam int unsigned FLOOR_CODE = 1;

  // Cycles in an interval of a given number of microseconds.
  function automatic int unsigned us_to_cycles(input int unsigned clk_khz,
                                               input int unsigned usec);
    return (clk_khz * usec) / 1000;
  endfunction

endpackage

// File: rtl/dvs_pacer.sv
// Interval counter: emits a one-cycle tick at the end of each step or
// soft-start interval. The counter restarts on every phase change.
module dvs_pacer #(
  parameter int unsigned SMALL_CYC = 300,
  parameter int unsigned LARGE_CYC = 600,
  parameter int unsigned SOFT_CYC  = 20000,
  localparam int unsigned MAX_CYC  = (SOFT_CYC > LARGE_CYC) ?
                                     ((SOFT_CYC > SMALL_CYC) ? SOFT_CYC : SMALL_CYC) :
                                     ((LARGE_CYC > SMALL_CYC) ? LARGE_CYC : SMALL_CYC),
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,         // a timed phase is active
  input  logic restart,     // phase changes at the coming edge
  input  logic soft_mode,   // time the soft-start phase
  input  logic step_large,  // slow step pace
  output logic tick
);

  localparam logic [CNT_W-1:0] SMALL_LAST = CNT_W'(SMALL_CYC - 1);
  localparam logic [CNT_W-1:0] LARGE_LAST = CNT_W'(LARGE_CYC - 1);
  localparam logic [CNT_W-1:0] SOFT_LAST  = CNT_W'(SOFT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] last;
  logic             cnt_en;

  // Limit picked live; ">=" keeps a mid-interval pace change from overrunning.
  always_comb begin
    if (soft_mode) begin
      last = SOFT_LAST;
    end else if (step_large) begin
      last = LARGE_LAST;
    end else begin
      last = SMALL_LAST;
    end
  end

  assign tick = run && (cnt_q >= last);

  always_comb begin
    cnt_en = 1'b1;
    if (!run || restart || tick) begin
      cnt_d = '0;
      cnt_en = (cnt_q != '0);
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/dvs_step_unit.sv
// Target decode and one-code step toward the effective target.
module dvs_step_unit #(
  parameter int unsigned VID_W = 7
) (
  input  logic [VID_W-1:0] cur,
  input  logic [VID_W-1:0] tgt,
  output logic [VID_W-1:0] eff,      // target with code 0 mapped to the floor
  output logic [VID_W-1:0] nxt,      // cur moved one code toward eff
  output logic             at_tgt,   // cur already equals eff
  output logic             nxt_hit,  // nxt equals eff
  output logic             tgt_off,  // shutdown request
  output logic             tgt_wake  // target above the floor code
);

  import dvs_vid_pkg::*;

  localparam logic [VID_W-1:0] FLOOR = VID_W'(FLOOR_CODE);

  always_comb begin
    tgt_off  = (tgt == '0);
    tgt_wake = (tgt > FLOOR);
    eff      = tgt_off ? FLOOR : tgt;
    at_tgt   = (cur == eff);
    if (at_tgt) begin
      nxt = cur;
    end else if (eff > cur) begin
      nxt = cur + 1'b1;
    end else begin
      nxt = cur - 1'b1;
    end
    nxt_hit = (nxt == eff);
  end

endmodule

// File: rtl/dvs_vid_seq.sv
// Dynamic voltage scaling sequencer for one buck converter.
module dvs_vid_seq #(
  parameter int unsigned CLK_KHZ       = 100000,
  parameter int unsigned VID_W         = 7,
  parameter int unsigned STEP_US_SMALL = 3,
  parameter int unsigned STEP_US_LARGE = 6,
  parameter int unsigned SOFT_US       = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VID_W-1:0] tgt_vid,
  input  logic             step_large,
  input  logic             decay_en,
  input  logic             below_floor,
  output logic [VID_W-1:0] vid,
  output logic             sw_en,
  output logic             force_pwm,
  output logic             ss_active,
  output logic             pg_mask
);

  import dvs_vid_pkg::*;

  localparam int unsigned SMALL_CYC = us_to_cycles(CLK_KHZ, STEP_US_SMALL);
  localparam int unsigned LARGE_CYC = us_to_cycles(CLK_KHZ, STEP_US_LARGE);
  localparam int unsigned SOFT_CYC  = us_to_cycles(CLK_KHZ, SOFT_US);
  localparam logic [VID_W-1:0] FLOOR = VID_W'(FLOOR_CODE);

  seq_state_t       state_q, state_d;
  logic [VID_W-1:0] vid_q, vid_d;
  logic             vid_en;

  logic [VID_W-1:0] eff_tgt, step_vid;
  logic             at_tgt, step_hits, tgt_off, tgt_wake;
  logic             tick, timed, phase_chg;

  // Target decode and stepping arithmetic.
  dvs_step_unit #(.VID_W(VID_W)) u_step (
    .cur      (vid_q),
    .tgt      (tgt_vid),
    .eff      (eff_tgt),
    .nxt      (step_vid),
    .at_tgt   (at_tgt),
    .nxt_hit  (step_hits),
    .tgt_off  (tgt_off),
    .tgt_wake (tgt_wake)
  );

  assign timed     = (state_q == SEQ_SOFT) || (state_q == SEQ_RAMP) ||
                     (state_q == SEQ_SETTLE);
  assign phase_chg = (state_d != state_q);

  // Step and soft-start pacing.
  dvs_pacer #(
    .SMALL_CYC (SMALL_CYC),
    .LARGE_CYC (LARGE_CYC),
    .SOFT_CYC  (SOFT_CYC)
  ) u_pacer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (timed),
    .restart    (phase_chg),
    .soft_mode  (state_q == SEQ_SOFT),
    .step_large (step_large),
    .tick       (tick)
  );

  // Next-state and next-code logic.
  always_comb begin
    state_d = state_q;
    vid_d   = vid_q;
    unique case (state_q)
      SEQ_OFF: begin
        vid_d = '0;
        if (tgt_wake) begin
          vid_d   = FLOOR;
          state_d = below_floor ? SEQ_SOFT : SEQ_RAMP;
        end
      end
      SEQ_SOFT: begin
        if (tick) begin
          state_d = SEQ_RAMP;
        end
      end
      SEQ_RAMP: begin
        if (tick) begin
          if (at_tgt) begin
            state_d = SEQ_SETTLE;
          end else begin
            vid_d = step_vid;
            if (step_hits) begin
              state_d = SEQ_SETTLE;
            end
          end
        end
      end
      SEQ_SETTLE: begin
        if (tick) begin
          if (tgt_off && at_tgt) begin
            state_d = SEQ_OFF;
            vid_d   = '0;
          end else if (!at_tgt) begin
            state_d = SEQ_RAMP;
          end else begin
            state_d = SEQ_HOLD;
          end
        end
      end
      SEQ_HOLD: begin
        if (tgt_off || !at_tgt) begin
          state_d = SEQ_RAMP;
        end
      end
      default: begin
        state_d = SEQ_OFF;
        vid_d   = '0;
      end
    endcase
  end

  assign vid_en = (vid_d != vid_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_OFF;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vid_q <= '0;
    end else if (vid_en) begin
      vid_q <= vid_d;
    end
  end

  // Output decode from the phase register.
  assign vid       = vid_q;
  assign sw_en     = (state_q != SEQ_OFF);
  assign ss_active = (state_q == SEQ_SOFT);
  assign pg_mask   = (state_q != SEQ_HOLD);
  assign force_pwm = ((state_q == SEQ_RAMP) || (state_q == SEQ_SETTLE)) && !decay_en;

endmodule

// File: rtl/dvs_vid_seq_chk.sv
// Cycle-level properties of the sequencer, observed at its ports.
module dvs_vid_seq_chk #(
  parameter int unsigned VID_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [VID_W-1:0] tgt_vid,
  input logic [VID_W-1:0] vid,
  input logic             sw_en,
  input logic             force_pwm,
  input logic             ss_active,
  input logic             pg_mask
);

  a_r11_single_code_move: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && $past(sw_en)) |->
      (vid == $past(vid) || vid == VID_W'($past(vid) + 1'b1) ||
       vid == VID_W'($past(vid) - 1'b1)));

  a_r6_off_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |-> (vid == '0));

  a_r6_stop_from_floor: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_en) |-> ($past(vid) == VID_W'(1)));

  a_r7_soft_at_floor: assert property (@(posedge clk) disable iff (!rst_n)
    ss_active |-> (sw_en && vid == VID_W'(1) && !force_pwm));

  a_r4_no_pwm_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_mask |-> !force_pwm);

  a_r5_hold_on_target: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!pg_mask) && !pg_mask) |-> (vid == $past(tgt_vid)));

endmodule

bind dvs_vid_seq dvs_vid_seq_chk #(.VID_W(VID_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tgt_vid   (tgt_vid),
  .vid       (vid),
  .sw_en     (sw_en),
  .force_pwm (force_pwm),
  .ss_active (ss_active),
  .pg_mask   (pg_mask)
);

// File: tb/dvs_vid_seq_tb.sv
module dvs_vid_seq_tb;

  localparam int CLK_KHZ = 10000;                // scaled pacing for a short run
  localparam int L_S  = CLK_KHZ * 3 / 1000;      // R3: 10 mV pace
  localparam int L_L  = CLK_KHZ * 6 / 1000;      // R3: 25 mV pace
  localparam int SOFT = CLK_KHZ * 200 / 1000;    // R7: soft-start length

  // Vector: {target[8:2], step_large[1], decay_en[0]}
  localparam int NV = 6;
  localparam logic [8:0] VEC [NV] = '{
    {7'd25, 1'b0, 1'b0},
    {7'd18, 1'b1, 1'b1},
    {7'd40, 1'b1, 1'b0},
    {7'd9,  1'b0, 1'b0},
    {7'd12, 1'b0, 1'b1},
    {7'd30, 1'b1, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] tgt_vid;
  logic       step_large, decay_en, below_floor;
  logic [6:0] vid;
  logic       sw_en, force_pwm, ss_active, pg_mask;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dvs_vid_seq #(.CLK_KHZ(CLK_KHZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .tgt_vid(tgt_vid), .step_large(step_large),
    .decay_en(decay_en), .below_floor(below_floor), .vid(vid), .sw_en(sw_en),
    .force_pwm(force_pwm), .ss_active(ss_active), .pg_mask(pg_mask)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, act=%0d exp<=150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: act=%0d exp=%0d", rq, what, act, exp);
    end
  endtask

  // Follow a ramp to completion, checking pace, direction, mode and mask.
  task automatic follow(input int tgt, input int lim, input int first,
                        input bit dec, input string rq);
    int eff = (tgt == 0) ? 1 : tgt;
    int cur = int'(vid);
    int gap, exp_v;
    bit bad, first_step;
    first_step = 1;
    while (cur != eff) begin
      gap = 0; bad = 0;
      do begin
        @(negedge clk); gap++;
        if (force_pwm !== ~dec || pg_mask !== 1'b1) bad = 1;
      end while (int'(vid) == cur && gap < 5000);
      chk(gap == (first_step ? first : lim), "R3", {rq, " step interval"}, gap,
          first_step ? first : lim);
      exp_v = (eff > cur) ? cur + 1 : cur - 1;
      chk(int'(vid) == exp_v, "R2", {rq, " next code"}, int'(vid), exp_v);
      chk(!bad, "R4", {rq, " pwm/mask while stepping"}, int'(bad), 0);
      cur = int'(vid);
      first_step = 0;
    end
    gap = 0; bad = 0;
    while (gap < 5000) begin
      @(negedge clk); gap++;
      if ((tgt == 0) ? !sw_en : !pg_mask) break;
      if (force_pwm !== ~dec || pg_mask !== 1'b1) bad = 1;
    end
    chk(!bad, "R4", {rq, " pwm/mask while settling"}, int'(bad), 0);
    if (tgt == 0) begin
      chk(gap == lim, "R6", "switch-off delay", gap, lim);
      chk(vid == 7'd0 && pg_mask && !force_pwm, "R6", "off state code", int'(vid), 0);
    end else begin
      chk(gap == lim, "R5", {rq, " unmask delay"}, gap, lim);
      chk(int'(vid) == tgt && !force_pwm, "R5", {rq, " final code"}, int'(vid), tgt);
    end
  endtask

  initial begin
    int n;
    rst_n = 1'b0; tgt_vid = '0; step_large = 0; decay_en = 0; below_floor = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(vid == 0 && !sw_en && !force_pwm && !ss_active && pg_mask, "R1",
        "reset outputs", int'(vid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(vid == 0 && !sw_en && pg_mask, "R1", "after release", int'(sw_en), 0);

    // R7: soft-start wake from below the floor
    below_floor = 1; tgt_vid = 7'd20;
    @(negedge clk);
    chk(vid == 1 && sw_en && ss_active && !force_pwm, "R7", "soft-start entry",
        int'(ss_active), 1);
    n = 1;
    while (n < 5000) begin
      @(negedge clk);
      if (!ss_active) break;
      n++;
      if (force_pwm || vid != 7'd1) chk(0, "R7", "pwm/code in soft-start", int'(vid), 1);
    end
    chk(n == SOFT, "R7", "soft-start length", n, SOFT);
    below_floor = 0;
    follow(20, L_S, L_S, 0, "R7");

    // R2/R3/R4/R5: table of ramps from a steady state
    for (int i = 0; i < NV; i++) begin
      tgt_vid = VEC[i][8:2]; step_large = VEC[i][1]; decay_en = VEC[i][0];
      follow(int'(VEC[i][8:2]), VEC[i][1] ? L_L : L_S,
             (VEC[i][1] ? L_L : L_S) + 1, VEC[i][0], "R2");
    end

    // R10: reversal during a ramp
    tgt_vid = 7'd40; step_large = 0; decay_en = 0;
    n = 0;
    while (vid != 7'd32 && n < 5000) begin @(negedge clk); n++; end
    tgt_vid = 7'd5;
    follow(5, L_S, L_S, 0, "R10");

    // R6: shutdown to zero
    tgt_vid = 7'd0;
    follow(0, L_S, L_S + 1, 0, "R6");

    // R9: floor-or-zero target while off is ignored
    tgt_vid = 7'd1; below_floor = 1;
    n = 0;
    repeat (50) begin
      @(negedge clk);
      if (sw_en || vid != 0) n++;
    end
    chk(n == 0, "R9", "stayed off", n, 0);

    // R8: wake above the floor, no soft-start
    below_floor = 0; step_large = 1; tgt_vid = 7'd4;
    @(negedge clk);
    chk(vid == 1 && sw_en && !ss_active, "R8", "direct wake", int'(vid), 1);
    follow(4, L_L, L_L, 0, "R8");

    // R1: reset in the middle of a ramp
    tgt_vid = 7'd50; step_large = 0;
    repeat (L_S * 3) @(negedge clk);
    rst_n = 1'b0; tgt_vid = 7'd0;
    @(negedge clk);
    chk(vid == 0 && !sw_en && !force_pwm && !ss_active && pg_mask, "R1",
        "mid-ramp reset", int'(vid), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(vid == 0 && !sw_en, "R1", "off after release", int'(sw_en), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule